// File: doc/BRIEF.md
# CCD Timing Pulse Conditioner and Output Latency Pipeline

This block sits between the externally supplied CCD timing pulses and the rest of an image-sensor front end. It takes four raw pulses: reference sample, data sample, dummy-pixel clamp and black-pixel clamp. Each pulse has its own polarity bit, and the block turns each one into a registered active-high enable. The input clamp enable is derived from two of these pulses. A fifth raw pulse, the pre-blank input, is active low. It produces an input-disconnect enable. A flag reports when the black clamp and pre-blank are active at the same time, because that spoils the black reference.

The second half of the block delays the 12-bit conversion word so that it appears at the correct output latency. Outside pre-blank the latency is 9 sample clocks. When pre-blank has been seen within the last 11 edges, the latency becomes 11 clocks. Samples taken while pre-blank was active are marked as they enter the shift chain, and they leave it as zero. A standby bit forces the output to zero on the next edge, but the chain keeps moving underneath.

Top module: `ccdPulsePipe`

## Requirements
- R1: After each rising edge, refSample, dataSample and blackLoopEn are each 1 exactly when the matching raw pulse sampled at that edge equals its polarity bit. A polarity bit of 1 means active high and 0 means active low.
- R2: After each rising edge, clampEn is 1 exactly when both the dummy-clamp pulse and the reference-sample pulse were active, after polarity correction, at that edge.
- R3: After each rising edge, inputDisconnect is 1 exactly when rawBlank was sampled low at that edge.
- R4: If rawBlank was high at edge n and at the 10 edges before it, outWord after edge n equals the convWord sampled at edge n-8, which is a latency of 9 clocks.
- R5: If rawBlank was low at edge n or at any of the 10 edges before it, outWord after edge n equals the convWord sampled at edge n-10, which is a latency of 11 clocks.
- R6: In the mode of R5, when rawBlank was low at edge n-10, outWord after edge n is zero. This holds from the 11th edge after pre-blank falls.
- R7: If standby is 1 at edge n, outWord after edge n is zero. After standby drops, the output follows R4 to R6 at the very next edge, with no refill delay.
- R8: After each rising edge, blackDuringBlank is 1 exactly when the black-clamp pulse was active and rawBlank was low at that edge.
- R9: While rstN is low, every output is 0. Words sampled before reset release count as zero, with no pre-blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rawRef | input | 1 | Raw reference-sample pulse |
| rawData | input | 1 | Raw data-sample pulse |
| rawDummy | input | 1 | Raw dummy-pixel clamp pulse |
| rawBlack | input | 1 | Raw black-pixel clamp pulse |
| rawBlank | input | 1 | Pre-blank pulse, active low |
| polRef | input | 1 | Polarity of rawRef, 1 = active high |
| polData | input | 1 | Polarity of rawData, 1 = active high |
| polDummy | input | 1 | Polarity of rawDummy, 1 = active high |
| polBlack | input | 1 | Polarity of rawBlack, 1 = active high |
| standby | input | 1 | Standby request, forces zero output |
| convWord | input | 12 | Conversion word entering the pipeline |
| refSample | output | 1 | Reference sample enable |
| dataSample | output | 1 | Data sample enable |
| clampEn | output | 1 | Input clamp enable |
| blackLoopEn | output | 1 | Black-level loop enable |
| inputDisconnect | output | 1 | Input disconnect enable |
| blackDuringBlank | output | 1 | Black clamp overlaps pre-blank |
| outWord | output | 12 | Delayed, blanked output word |

## Verification
All enables and the overlap flag are due one edge after their raw inputs are sampled. The output word is due after edge n and depends on what was sampled at edges n-10 through n. The bench keeps a per-edge history of every driven input. After each edge it computes the expected values from that history and samples the outputs 1 ns later, away from the next edge. Pre-blank bursts of random length, including single-cycle bursts, exercise the switch between the two latencies in both directions.

// File: rtl/ccdPipePkg.sv
package ccdPipePkg;
  // strobes handed from the pulse control to the output datapath
  typedef struct packed {
    logic blankNow;    // pre-blank active at this edge
    logic standbyNow;  // standby requested at this edge
  } pipeStrobeT;

  localparam int PULSE_COUNT = 4;
  localparam int IDX_REF   = 0;
  localparam int IDX_DATA  = 1;
  localparam int IDX_DUMMY = 2;
  localparam int IDX_BLACK = 3;
endpackage

// File: rtl/ccdPulseCtrl.sv
module ccdPulseCtrl
  import ccdPipePkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PULSE_COUNT-1:0] rawPulse,
  input  logic [PULSE_COUNT-1:0] polBits,
  input  logic                   rawBlank,
  input  logic                   standby,
  output logic                   refSample,
  output logic                   dataSample,
  output logic                   clampEn,
  output logic                   blackLoopEn,
  output logic                   inputDisconnect,
  output logic                   blackDuringBlank,
  output pipeStrobeT             strobe
);
  logic [PULSE_COUNT-1:0] pulseActive;

  // polarity correction: a pulse is active when its level equals its polarity bit
  genvar gi;
  generate
    for (gi = 0; gi < PULSE_COUNT; gi++) begin : gPol
      assign pulseActive[gi] = (rawPulse[gi] == polBits[gi]);
    end
  endgenerate

  always_comb begin
    strobe.blankNow   = ~rawBlank;
    strobe.standbyNow = standby;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSample        <= 1'b0;
      dataSample       <= 1'b0;
      clampEn          <= 1'b0;
      blackLoopEn      <= 1'b0;
      inputDisconnect  <= 1'b0;
      blackDuringBlank <= 1'b0;
    end else begin
      refSample        <= pulseActive[IDX_REF];
      dataSample       <= pulseActive[IDX_DATA];
      clampEn          <= pulseActive[IDX_DUMMY] & pulseActive[IDX_REF];
      blackLoopEn      <= pulseActive[IDX_BLACK];
      inputDisconnect  <= ~rawBlank;
      blackDuringBlank <= pulseActive[IDX_BLACK] & ~rawBlank;
    end
  end
endmodule

// File: rtl/ccdOutPipe.sv
module ccdOutPipe
  import ccdPipePkg::*;
#(
  parameter int WIDTH     = 12,
  parameter int SHORT_LAT = 9,
  parameter int LONG_LAT  = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  pipeStrobeT       strobe,
  input  logic [WIDTH-1:0] convWord,
  output logic [WIDTH-1:0] outWord
);
  // the output register is the last stage, so the chain holds LAT-1 words
  localparam int DEPTH     = LONG_LAT - 1;
  localparam int SHORT_IDX = SHORT_LAT - 2;
  localparam int LONG_IDX  = LONG_LAT - 2;

  logic [WIDTH-1:0] stageWord [DEPTH];
  logic [DEPTH-1:0] stageZero;
  logic             longMode;
  logic [WIDTH-1:0] longTap;
  logic [WIDTH-1:0] nextOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageWord[0] <= '0;
      stageZero[0] <= 1'b0;
    end else begin
      stageWord[0] <= convWord;
      stageZero[0] <= strobe.blankNow;
    end
  end

  genvar gs;
  generate
    for (gs = 1; gs < DEPTH; gs++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stageWord[gs] <= '0;
          stageZero[gs] <= 1'b0;
        end else begin
          stageWord[gs] <= stageWord[gs-1];
          stageZero[gs] <= stageZero[gs-1];
        end
      end
    end
  endgenerate

  always_comb begin
    longMode = strobe.blankNow | (|stageZero);
    longTap  = stageZero[LONG_IDX] ? '0 : stageWord[LONG_IDX];
    if (strobe.standbyNow) nextOut = '0;
    else if (longMode)     nextOut = longTap;
    else                   nextOut = stageWord[SHORT_IDX];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outWord <= '0;
    else       outWord <= nextOut;
  end
endmodule

// File: rtl/ccdPulsePipe.sv
module ccdPulsePipe
  import ccdPipePkg::*;
#(
  parameter int WIDTH     = 12,
  parameter int SHORT_LAT = 9,
  parameter int LONG_LAT  = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawRef,
  input  logic             rawData,
  input  logic             rawDummy,
  input  logic             rawBlack,
  input  logic             rawBlank,
  input  logic             polRef,
  input  logic             polData,
  input  logic             polDummy,
  input  logic             polBlack,
  input  logic             standby,
  input  logic [WIDTH-1:0] convWord,
  output logic             refSample,
  output logic             dataSample,
  output logic             clampEn,
  output logic             blackLoopEn,
  output logic             inputDisconnect,
  output logic             blackDuringBlank,
  output logic [WIDTH-1:0] outWord
);
  pipeStrobeT strobe;

  ccdPulseCtrl uCtrl (
    .clk              (clk),
    .rstN             (rstN),
    .rawPulse         ({rawBlack, rawDummy, rawData, rawRef}),
    .polBits          ({polBlack, polDummy, polData, polRef}),
    .rawBlank         (rawBlank),
    .standby          (standby),
    .refSample        (refSample),
    .dataSample       (dataSample),
    .clampEn          (clampEn),
    .blackLoopEn      (blackLoopEn),
    .inputDisconnect  (inputDisconnect),
    .blackDuringBlank (blackDuringBlank),
    .strobe           (strobe)
  );

  ccdOutPipe #(
    .WIDTH     (WIDTH),
    .SHORT_LAT (SHORT_LAT),
    .LONG_LAT  (LONG_LAT)
  ) uPipe (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .convWord (convWord),
    .outWord  (outWord)
  );
endmodule

// File: rtl/ccdPulsePipeChk.sv
module ccdPulsePipeChk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             rawRef,
  input logic             rawDummy,
  input logic             rawBlack,
  input logic             rawBlank,
  input logic             polRef,
  input logic             polDummy,
  input logic             polBlack,
  input logic             standby,
  input logic             refSample,
  input logic             clampEn,
  input logic             blackLoopEn,
  input logic             inputDisconnect,
  input logic             blackDuringBlank,
  input logic [WIDTH-1:0] outWord
);
  AST_REF_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    (rawRef == polRef) |=> refSample); // R1

  AST_CLAMP_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (rawDummy == polDummy && rawRef == polRef) |=> clampEn); // R2

  AST_CLAMP_IMPLIES_REF: assert property (@(posedge clk) disable iff (!rstN)
    clampEn |-> refSample); // R2

  AST_BLANK_DISCONNECT: assert property (@(posedge clk) disable iff (!rstN)
    !rawBlank |=> inputDisconnect); // R3

  AST_STANDBY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (outWord == '0)); // R7

  AST_OVERLAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    blackDuringBlank |-> (blackLoopEn && inputDisconnect)); // R8

  AST_OVERLAP_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (rawBlack == polBlack && !rawBlank) |=> blackDuringBlank); // R8

  always_comb begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (outWord == '0 && !clampEn && !blackDuringBlank); // R9
    end
  end
endmodule

bind ccdPulsePipe ccdPulsePipeChk #(.WIDTH(WIDTH)) uChk (
  .clk              (clk),
  .rstN             (rstN),
  .rawRef           (rawRef),
  .rawDummy         (rawDummy),
  .rawBlack         (rawBlack),
  .rawBlank         (rawBlank),
  .polRef           (polRef),
  .polDummy         (polDummy),
  .polBlack         (polBlack),
  .standby          (standby),
  .refSample        (refSample),
  .clampEn          (clampEn),
  .blackLoopEn      (blackLoopEn),
  .inputDisconnect  (inputDisconnect),
  .blackDuringBlank (blackDuringBlank),
  .outWord          (outWord)
);

// File: tb/test_ccdPulsePipe.sv
`timescale 1ns/1ps
module test_ccdPulsePipe;
  localparam int W = 12;
  localparam int MAXC = 2048;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawRef = 1'b1, rawData = 1'b1, rawDummy = 1'b1, rawBlack = 1'b1, rawBlank = 1'b1;
  logic polRef = 1'b0, polData = 1'b0, polDummy = 1'b0, polBlack = 1'b0;
  logic standby = 1'b0;
  logic [W-1:0] convWord = '0;
  logic refSample, dataSample, clampEn, blackLoopEn, inputDisconnect, blackDuringBlank;
  logic [W-1:0] outWord;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int cyc = 0;

  logic [W-1:0] hWord [MAXC];
  bit hBlank [MAXC];
  bit hStandby [MAXC];

  always #2.5 clk = ~clk;

  ccdPulsePipe i_ccdPulsePipe (
    .clk(clk), .rstN(rstN), .rawRef(rawRef), .rawData(rawData), .rawDummy(rawDummy),
    .rawBlack(rawBlack), .rawBlank(rawBlank), .polRef(polRef), .polData(polData),
    .polDummy(polDummy), .polBlack(polBlack), .standby(standby), .convWord(convWord),
    .refSample(refSample), .dataSample(dataSample), .clampEn(clampEn),
    .blackLoopEn(blackLoopEn), .inputDisconnect(inputDisconnect),
    .blackDuringBlank(blackDuringBlank), .outWord(outWord)
  );

  function automatic logic [W-1:0] wordAt(int n);
    return (n < 0) ? '0 : hWord[n];
  endfunction

  function automatic bit blankAt(int n);
    return (n < 0) ? 1'b0 : hBlank[n];
  endfunction

  function automatic logic [W-1:0] expOut(int n);
    bit longMode = 1'b0;
    for (int k = n - 10; k <= n; k++) if (blankAt(k)) longMode = 1'b1;
    if (hStandby[n]) return '0;
    if (longMode) return blankAt(n - 10) ? '0 : wordAt(n - 10);
    return wordAt(n - 8);
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  // drive one edge worth of inputs, then check after the edge
  task automatic step(bit blankLow, bit sb, logic [W-1:0] w);
    bit aRef, aData, aDummy, aBlack;
    @(negedge clk);
    rawBlank = ~blankLow;
    standby = sb;
    convWord = w;
    hWord[cyc] = w;
    hBlank[cyc] = blankLow;
    hStandby[cyc] = sb;
    aRef   = (rawRef == polRef);
    aData  = (rawData == polData);
    aDummy = (rawDummy == polDummy);
    aBlack = (rawBlack == polBlack);
    @(posedge clk);
    #1;
    check("R1 refSample", {11'd0, refSample}, {11'd0, aRef});
    check("R1 dataSample", {11'd0, dataSample}, {11'd0, aData});
    check("R1 blackLoopEn", {11'd0, blackLoopEn}, {11'd0, aBlack});
    check("R2 clampEn", {11'd0, clampEn}, {11'd0, aDummy & aRef});
    check("R3 inputDisconnect", {11'd0, inputDisconnect}, {11'd0, blankLow});
    check("R8 blackDuringBlank", {11'd0, blackDuringBlank}, {11'd0, aBlack & blankLow});
    check("R4 R5 R6 R7 outWord", outWord, expOut(cyc));
    cyc++;
  endtask

  task automatic randomPulses();
    rawRef = 1'($urandom); rawData = 1'($urandom);
    rawDummy = 1'($urandom); rawBlack = 1'($urandom);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7531));
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check("R9 outWord reset", outWord, '0);
    check("R9 enables reset", {6'd0, refSample, dataSample, clampEn, blackLoopEn,
          inputDisconnect, blackDuringBlank}, '0);
    @(negedge clk);
    rstN = 1'b1;

    // R4: clean ramp, latency 9
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, W'(i * 37 + 5));
    // R5 R6: single-cycle pre-blank, latency switches to 11 and back
    step(1'b1, 1'b0, 12'hABC);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, W'(i + 100));
    // R6: long pre-blank burst
    for (int i = 0; i < 15; i++) step(1'b1, 1'b0, 12'hFFF);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, W'(i * 91));
    // R7: one-cycle standby, output resumes at once
    step(1'b0, 1'b1, 12'h555);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, W'(i + 3000));
    // R1 R2 R8: polarity flips, both levels
    polRef = 1'b1; polDummy = 1'b1; polBlack = 1'b1; polData = 1'b1;
    rawRef = 1'b1; rawDummy = 1'b1; rawBlack = 1'b1;
    step(1'b1, 1'b0, 12'h123);
    rawDummy = 1'b0;
    step(1'b0, 1'b0, 12'h124);

    // constrained random mix
    for (int r = 0; r < 1000; r++) begin
      if ((r % 97) == 0) begin
        polRef = 1'($urandom); polData = 1'($urandom);
        polDummy = 1'($urandom); polBlack = 1'($urandom);
      end
      randomPulses();
      step(($urandom % 8) == 0, ($urandom % 20) == 0, W'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule